// File: doc/BRIEF.md
# Indirect User-Bit Readout Buffer

This block gathers the user bits carried in a digital audio stream, one bit per frame, into a block of 24 bytes. A marker that arrives with the first bit of each block starts the collection. When all 192 bits of a block are in, the whole block is copied at once into a second, host-facing copy. A block that is still arriving therefore never changes the bytes the host is reading.

The host reaches the bytes through two registers. It first writes a byte offset into an index register. It then reads a data register again and again. Each data read returns the byte at the current offset and moves the offset on by one. After the last byte the offset wraps back to the first. Read data is registered and appears on the cycle after the read strobe.

Top module: `ubit_buffer_port`

## Requirements
- R1: After reset the offset is 0, the read data output is 0, and every byte of the host copy reads as 0.
- R2: Bit k of a block (k = 0 first) lands in byte k/8 at bit position k mod 8, so the first bit of each byte is its LSB (default ordering).
- R3: The host copy changes only on the clock edge that follows the 192nd bit of a block opened by a block-start marker. A partial block is never visible.
- R4: A bit with the block-start marker restarts collection at bit 0 and drops any partial block. Bits without the marker are ignored before the first marker, and again after a block completes until the next marker.
- R5: A read at address 0x51 returns, on the next cycle, the byte at the current offset, and the offset advances by one.
- R6: A data read at offset 23 returns byte 23 and leaves the offset at 0.
- R7: A write to address 0x50 sets the offset to the written value. A value of 24 or more sets it to 23.
- R8: A read at address 0x50 returns the current offset, zero-extended, on the next cycle and does not change it.
- R9: A data read made in the cycle right after a block's final bit, which is the cycle of the copy, returns the previous block's byte. The offset still advances.
- R10: Writes to address 0x51 and to unmapped addresses have no effect. Reads of unmapped addresses return 0 and leave the offset alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ub_valid | input | 1 | A user bit is present this cycle |
| ub_bit | input | 1 | User bit value |
| ub_block_start | input | 1 | This bit is the first of a block |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |

## Verification
Full blocks of random bytes, some with idle gaps between bits, are read back from random start offsets with runs long enough to wrap. These runs separate correct bit placement and offset stepping from off-by-one and ordering faults. A block with a single set bit pins down the bit position within a byte. Partial blocks cut short by a new marker, and stray bits with no marker, show whether incomplete data can leak into the host copy. A read placed in the copy cycle, together with index writes of 23, 24, 30 and 255, shows the old-data rule and the clamping boundary apart from plain wrap behaviour.

// File: rtl/ubit_pkg.sv
package ubit_pkg;
   // Register decode outcome for one host access.
   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_INDEX = 2'd1,
      SEL_DATA  = 2'd2
   } reg_sel_e;

   // Number of bits gathered per byte of the buffer.
   localparam int unsigned BITS_PER_BYTE = 8;
endpackage

// File: rtl/ubit_collect.sv
module ubit_collect #(
   parameter int unsigned NUM_BYTES = 24,
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic                                        clk,
   input  logic                                        rst_n,
   input  logic                                        bit_valid,
   input  logic                                        bit_in,
   input  logic                                        block_start,
   output logic [NUM_BYTES*ubit_pkg::BITS_PER_BYTE-1:0] fill_o,
   output logic                                        done_o
);
   localparam int unsigned NUM_BITS = NUM_BYTES * ubit_pkg::BITS_PER_BYTE;
   localparam int unsigned CW       = $clog2(NUM_BITS);
   localparam logic [CW-1:0] LAST_BIT = CW'(NUM_BITS - 1);
   localparam logic [CW-1:0] POS0     = LSB_FIRST ? '0 : CW'(7);

   logic [NUM_BITS-1:0] fill_q;
   logic [CW-1:0]       cnt_q;
   logic [CW-1:0]       wpos;
   logic                armed_q;
   logic                done_q;

   // Bit placement variant inside each byte.
   generate
      if (LSB_FIRST) begin : g_lsb_first
         assign wpos = cnt_q;
      end else begin : g_msb_first
         assign wpos = cnt_q ^ CW'(7);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill_q  <= '0;
         cnt_q   <= '0;
         armed_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (bit_valid) begin
            if (block_start) begin
               fill_q[POS0] <= bit_in;
               cnt_q        <= CW'(1);
               armed_q      <= 1'b1;
            end else if (armed_q) begin
               fill_q[wpos] <= bit_in;
               if (cnt_q == LAST_BIT) begin
                  cnt_q   <= '0;
                  armed_q <= 1'b0;
                  done_q  <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + CW'(1);
               end
            end
         end
      end
   end

   assign fill_o = fill_q;
   assign done_o = done_q;

   // R4: a completed block leaves the collector idle until the next marker
   a_r4_done_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !armed_q);
   // R4: while idle, bits without a marker cannot complete a block
   a_r4_idle_no_done: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed_q && !(bit_valid && block_start)) |=> !done_q);
endmodule

// File: rtl/ubit_hold.sv
module ubit_hold #(
   parameter int unsigned NUM_BYTES = 24,
   parameter int unsigned PW        = 5
) (
   input  logic                                        clk,
   input  logic                                        rst_n,
   input  logic                                        xfer,
   input  logic [NUM_BYTES*ubit_pkg::BITS_PER_BYTE-1:0] fill_i,
   input  logic [PW-1:0]                               sel,
   output logic [ubit_pkg::BITS_PER_BYTE-1:0]          byte_o
);
   localparam int unsigned BB = ubit_pkg::BITS_PER_BYTE;

   logic [NUM_BYTES*BB-1:0] host_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         host_q <= '0;
      end else if (xfer) begin
         host_q <= fill_i;
      end
   end

   assign byte_o = host_q[sel*BB +: BB];

   // R3: host copy only moves on a transfer
   a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer |=> $stable(host_q));
   // R3: a transfer takes the whole collected block
   a_r3_copy_whole: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |=> host_q == $past(fill_i));
endmodule

// File: rtl/ubit_index.sv
module ubit_index #(
   parameter int unsigned NUM_BYTES = 24,
   parameter int unsigned DW        = 8,
   parameter int unsigned PW        = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] load_val,
   input  logic          adv,
   output logic [PW-1:0] ptr_o
);
   localparam logic [PW-1:0] LASTP  = PW'(NUM_BYTES - 1);
   localparam logic [DW-1:0] LAST_W = DW'(NUM_BYTES - 1);

   logic [PW-1:0] ptr_q;
   logic [PW-1:0] load_ptr;

   assign load_ptr = (load_val > LAST_W) ? LASTP : load_val[PW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (load) begin
         ptr_q <= load_ptr;
      end else if (adv) begin
         ptr_q <= (ptr_q == LASTP) ? '0 : ptr_q + PW'(1);
      end
   end

   assign ptr_o = ptr_q;

   // R5: offset stays inside the buffer
   a_r5_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q <= LASTP);
   // R5: a data read below the last byte steps by one
   a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load && ptr_q != LASTP) |=> ptr_q == $past(ptr_q) + PW'(1));
   // R6: a data read at the last byte wraps to zero
   a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load && ptr_q == LASTP) |=> ptr_q == '0);
   // R7: oversized index writes pin to the last byte
   a_r7_clamp: assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_val > LAST_W) |=> ptr_q == LASTP);
   // R8: without load or advance the offset holds
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !adv) |=> $stable(ptr_q));
endmodule

// File: rtl/ubit_buffer_port.sv
module ubit_buffer_port #(
   parameter int unsigned NUM_BYTES = 24,
   parameter int unsigned AW        = 8,
   parameter int unsigned DW        = 8,
   parameter logic [7:0]  IDX_ADDR  = 8'h50,
   parameter logic [7:0]  DAT_ADDR  = 8'h51,
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ub_valid,
   input  logic          ub_bit,
   input  logic          ub_block_start,
   input  logic          reg_wr,
   input  logic          reg_rd,
   input  logic [AW-1:0] reg_addr,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata
);
   import ubit_pkg::*;

   localparam int unsigned PW = $clog2(NUM_BYTES);
   localparam int unsigned BB = BITS_PER_BYTE;

   // Elaboration-time parameter checks.
   generate
      if (NUM_BYTES < 2) begin : g_bad_depth
         $error("ubit_buffer_port: NUM_BYTES must be at least 2");
      end
      if (DW < BB || DW <= PW) begin : g_bad_width
         $error("ubit_buffer_port: DW too narrow for byte or offset");
      end
      if (AW < 8) begin : g_bad_addr
         $error("ubit_buffer_port: AW must hold the register addresses");
      end
   endgenerate

   logic [NUM_BYTES*BB-1:0] fill;
   logic                    xfer;
   logic [PW-1:0]           ptr;
   logic [BB-1:0]           cur_byte;
   reg_sel_e                sel;
   logic                    ld_idx;
   logic                    rd_dat;

   always_comb begin
      if (reg_addr == AW'(IDX_ADDR))      sel = SEL_INDEX;
      else if (reg_addr == AW'(DAT_ADDR)) sel = SEL_DATA;
      else                                sel = SEL_NONE;
   end

   assign ld_idx = reg_wr && (sel == SEL_INDEX);
   assign rd_dat = reg_rd && (sel == SEL_DATA);

   ubit_collect #(.NUM_BYTES(NUM_BYTES), .LSB_FIRST(LSB_FIRST)) i_collect (
      .clk(clk), .rst_n(rst_n), .bit_valid(ub_valid), .bit_in(ub_bit),
      .block_start(ub_block_start), .fill_o(fill), .done_o(xfer));

   ubit_hold #(.NUM_BYTES(NUM_BYTES), .PW(PW)) i_hold (
      .clk(clk), .rst_n(rst_n), .xfer(xfer), .fill_i(fill),
      .sel(ptr), .byte_o(cur_byte));

   ubit_index #(.NUM_BYTES(NUM_BYTES), .DW(DW), .PW(PW)) i_index (
      .clk(clk), .rst_n(rst_n), .load(ld_idx), .load_val(reg_wdata),
      .adv(rd_dat), .ptr_o(ptr));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_rdata <= '0;
      end else if (reg_rd) begin
         unique case (sel)
            SEL_DATA:  reg_rdata <= DW'(cur_byte);
            SEL_INDEX: reg_rdata <= DW'(ptr);
            default:   reg_rdata <= '0;
         endcase
      end
   end

   // R8: an index read reports the offset seen at the read
   a_r8_idx_read: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && sel == SEL_INDEX) |=> reg_rdata == DW'($past(ptr)));
   // R10: unmapped reads return zero
   a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && sel == SEL_NONE) |=> reg_rdata == '0);
   // R10: writes to the data register leave the offset alone
   a_r10_data_wr_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && sel != SEL_INDEX && !rd_dat) |=> $stable(ptr));
endmodule

// File: tb/test_ubit_buffer_port.sv
module test_ubit_buffer_port;
   localparam int CLK_PERIOD = 10;
   localparam int NB = 24;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ub_valid = 1'b0, ub_bit = 1'b0, ub_block_start = 1'b0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00;
   logic [7:0] reg_rdata;

   int checks = 0;
   int errors = 0;
   logic [7:0] exp_host [NB];
   logic [7:0] blk [NB];
   int exp_ptr = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ubit_buffer_port i_ubit_buffer_port (
      .clk(clk), .rst_n(rst_n), .ub_valid(ub_valid), .ub_bit(ub_bit),
      .ub_block_start(ub_block_start), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

   function automatic int next_ptr(input int p);
      return (p == NB - 1) ? 0 : p + 1;
   endfunction

   function automatic int clamp_ptr(input int v);
      return (v > NB - 1) ? NB - 1 : v;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // All tasks start and end just after a falling edge.
   task automatic rd(input logic [7:0] a, output logic [7:0] v);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
      v = reg_rdata;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_data_chk(input string tag);
      logic [7:0] v;
      rd(8'h51, v);
      check(tag, v, exp_host[exp_ptr]);
      exp_ptr = next_ptr(exp_ptr);
   endtask

   task automatic rd_idx_chk(input string tag);
      logic [7:0] v;
      rd(8'h50, v);
      check(tag, v, exp_ptr);
   endtask

   task automatic send(input int nbits, input bit with_start, input bit gaps);
      for (int k = 0; k < nbits; k++) begin
         if (gaps && ($urandom % 4 == 0)) begin
            ub_valid = 1'b0; ub_block_start = 1'b0;
            @(negedge clk);
         end
         ub_valid = 1'b1;
         ub_block_start = (k == 0) && with_start;
         ub_bit = blk[k / 8][k % 8];
         @(negedge clk);
      end
      ub_valid = 1'b0; ub_block_start = 1'b0;
   endtask

   task automatic commit();
      foreach (exp_host[i]) exp_host[i] = blk[i];
   endtask

   task automatic rand_blk();
      foreach (blk[i]) blk[i] = 8'($urandom);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0] v;
      void'($urandom(32'h5A17));
      foreach (exp_host[i]) exp_host[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check("R1 rdata", reg_rdata, 0);
      rd_idx_chk("R1 offset");
      for (int i = 0; i < NB; i++) rd_data_chk("R1 zero bytes");
      rd_idx_chk("R6 wrap after full pass");

      // R2: single set bit at k=13 lands in byte 1, bit 5
      foreach (blk[i]) blk[i] = 8'h00;
      blk[1] = 8'h20;
      send(192, 1'b1, 1'b0);
      @(negedge clk);
      commit();
      wr(8'h50, 8'd1); exp_ptr = 1;
      rd_data_chk("R2 bit position");

      // R2/R5: random full block, no gaps, read from offset 0
      rand_blk();
      send(192, 1'b1, 1'b0);
      @(negedge clk);
      commit();
      wr(8'h50, 8'd0); exp_ptr = 0;
      for (int i = 0; i < NB; i++) rd_data_chk("R2 R5 random block");

      // R9: read in the copy cycle returns the old byte
      wr(8'h50, 8'd7); exp_ptr = 7;
      rand_blk();
      send(192, 1'b1, 1'b1);
      rd_data_chk("R9 old byte in copy cycle");
      commit();
      rd_data_chk("R9 new byte after copy");

      // R3/R4: partial block then a fresh marker
      rand_blk();
      send(100, 1'b1, 1'b0);
      @(negedge clk);
      rd_data_chk("R3 partial not visible");
      rand_blk();
      send(192, 1'b1, 1'b0);
      @(negedge clk);
      commit();
      wr(8'h50, 8'd0); exp_ptr = 0;
      for (int i = 0; i < NB; i++) rd_data_chk("R4 restart block");

      // R4: bits without a marker after completion are ignored
      rand_blk();
      send(192, 1'b0, 1'b0);
      @(negedge clk);
      for (int i = 0; i < NB; i++) rd_data_chk("R4 stray bits ignored");

      // R7: clamping of index writes
      wr(8'h50, 8'd30); exp_ptr = clamp_ptr(30);
      rd_idx_chk("R7 clamp 30");
      wr(8'h50, 8'd24); exp_ptr = clamp_ptr(24);
      rd_idx_chk("R7 clamp 24");
      wr(8'h50, 8'd255); exp_ptr = clamp_ptr(255);
      rd_idx_chk("R7 clamp 255");
      wr(8'h50, 8'd23); exp_ptr = 23;
      rd_idx_chk("R7 exact 23");
      rd_data_chk("R6 last byte");
      rd_idx_chk("R6 wrapped to 0");

      // R8: index reads have no side effects
      wr(8'h50, 8'd5); exp_ptr = 5;
      rd_idx_chk("R8 first read");
      rd_idx_chk("R8 second read");
      rd_data_chk("R8 data after index reads");

      // R10: data writes and unmapped accesses are inert
      wr(8'h51, 8'hA5);
      wr(8'h52, 8'h03);
      rd_idx_chk("R10 offset after writes");
      rd(8'h52, v);
      check("R10 unmapped read", v, 0);
      rd_idx_chk("R10 offset after unmapped read");
      rd_data_chk("R10 byte unchanged");

      // Random mix
      for (int it = 0; it < 8; it++) begin
         int p;
         int n;
         rand_blk();
         if ($urandom % 2 == 0) begin
            send(20 + int'($urandom % 150), 1'b1, 1'b1);
            rand_blk();
         end
         send(192, 1'b1, 1'b1);
         @(negedge clk);
         commit();
         p = int'($urandom % 40);
         wr(8'h50, 8'(p)); exp_ptr = clamp_ptr(p);
         n = 1 + int'($urandom % 30);
         for (int r = 0; r < n; r++) begin
            if ($urandom % 5 == 0) rd_idx_chk("R8 random index read");
            else rd_data_chk("R5 R6 random read");
         end
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule